// File: doc/BRIEF.md
# Two-Stage Escalating Watchdog Timer

This block is a memory-mapped watchdog that escalates in two steps. It compares a free-running system counter, supplied as an input, against an internal compare value. When the counter first reaches that value, the block sets an interrupt status flag and pushes the deadline out by one more programmed offset. If software still has not serviced the watchdog when the counter reaches the new deadline, the block raises a reset request. That request holds until the block itself is reset. With the interrupt left unhandled, a reset therefore arrives two offset periods after the last service.

Software reaches the block through a plain register port that has two frames, selected by a frame input. The service frame holds only a kick register, and a write of any value to it services the watchdog. The control frame holds the control/status word, the offset, a read-only view of the 64-bit compare value, and identification words. A write to the control/status word also services the watchdog, so enabling, re-enabling and disabling all restart the timeout.

Top module: `wdog_escalate`

## Requirements
- R1: After reset, irq_o and rst_req_o are 0, the control/status word reads 0, and the offset reads RST_OFFSET (default 0).
- R2: A write of any data to service-frame address 0x000 (bus_frame=0) loads compare with the counter value sampled at that write edge plus the offset, and clears the first-stage flag.
- R3: A write to control-frame address 0x000 (bus_frame=1) stores data bit 0 as the enable and also services the watchdog as in R2. Data bits 1 and 2 of that write are ignored.
- R4: While enabled with the first-stage flag clear, the first counter value at or above compare sets the flag and reloads compare with that counter value plus the offset. irq_o equals the flag, so with offset N it rises N cycles after the servicing write edge.
- R5: While enabled with the first-stage flag set, reaching compare again sets the second-stage flag, and rst_req_o equals that flag. With offset N, rst_req_o rises 2N cycles after the last servicing write edge, one stage after irq_o.
- R6: Once the second-stage flag is set, it stays set through service writes and disable writes, and only rst_n clears it.
- R7: While the enable is 0, neither flag is set, however far the counter runs past compare. A control write of 0 clears irq_o.
- R8: With an offset of 0, irq_o rises one cycle after the enabling write edge and rst_req_o rises the cycle after that.
- R9: Control-frame read map: 0x000 gives {ws1, ws0, enable} in bits 2:0, 0x008 gives the offset, 0x010 and 0x014 give compare bits 31:0 and 63:32. In both frames, 0xFCC gives IFACE_ID and 0xFD0 gives PART_ID. Every other address, including service-frame 0x000, reads 0.
- R10: When a service write and a compare hit fall on the same edge, the service write wins, and no flag is set on that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sys_cnt | input | CNT_W | Free-running system counter value |
| bus_frame | input | 1 | Frame select: 0 = service frame, 1 = control frame |
| bus_addr | input | ADDR_W | Byte offset within the selected frame |
| bus_wr | input | 1 | Write strobe, one write per cycle |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for bus_frame/bus_addr, combinational |
| irq_o | output | 1 | First-stage timeout, interrupt request |
| rst_req_o | output | 1 | Second-stage timeout, sticky reset request |

## Verification
The escalation path is first driven with no service at all. This measures both the first-stage and the second-stage distance from the enabling write and shows that the second stage is armed by a reload, not by the first deadline. Services are then issued in three ways: through the kick register before the first stage, through the kick register after it, and through a control write with the status bits set. These separate a postponed deadline from a cleared flag and confirm that status bits cannot be written. A disable followed by a long idle, an offset of zero, and a service placed exactly on the hit edge isolate the enable gating, the back-to-back stage case and the priority of writes over hits. The system counter starts just below a 32-bit boundary, so the compare readback also checks the carry into the upper word.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

   localparam logic [11:0] OFS_KICK   = 12'h000;
   localparam logic [11:0] OFS_CTL    = 12'h000;
   localparam logic [11:0] OFS_PERIOD = 12'h008;
   localparam logic [11:0] OFS_CMP_LO = 12'h010;
   localparam logic [11:0] OFS_CMP_HI = 12'h014;
   localparam logic [11:0] OFS_IFID   = 12'hFCC;
   localparam logic [11:0] OFS_PARTID = 12'hFD0;

   typedef enum logic {
      FRAME_KICK = 1'b0,
      FRAME_CTL  = 1'b1
   } frame_e;

   typedef struct packed {
      logic ws1;
      logic ws0;
      logic en;
   } wd_status_t;

endpackage

// File: rtl/wdog_regdec.sv
module wdog_regdec
   import wdog_pkg::*;
#(
   parameter int unsigned          ADDR_W   = 12,
   parameter int unsigned          DATA_W   = 32,
   parameter int unsigned          OFF_W    = 32,
   parameter int unsigned          CNT_W    = 64,
   parameter logic [DATA_W-1:0]    IFACE_ID = '0,
   parameter logic [DATA_W-1:0]    PART_ID  = '0
) (
   input  logic                bus_frame,
   input  logic [ADDR_W-1:0]   bus_addr,
   input  logic                bus_wr,
   input  wd_status_t          status,
   input  logic [OFF_W-1:0]    period,
   input  logic [CNT_W-1:0]    cmp,
   output logic                kick,
   output logic                ctl_wr,
   output logic                period_wr,
   output logic [DATA_W-1:0]   rdata
);

   localparam int unsigned EXT_W = 2 * DATA_W;

   logic             in_ctl;
   logic [EXT_W-1:0] cmp_ext;

   assign in_ctl    = (bus_frame == FRAME_CTL);
   assign cmp_ext   = EXT_W'(cmp);
   assign ctl_wr    = bus_wr && in_ctl && (bus_addr == ADDR_W'(OFS_CTL));
   assign period_wr = bus_wr && in_ctl && (bus_addr == ADDR_W'(OFS_PERIOD));
   assign kick      = ctl_wr ||
                      (bus_wr && !in_ctl && (bus_addr == ADDR_W'(OFS_KICK)));

   always_comb begin
      rdata = '0;
      if (bus_addr == ADDR_W'(OFS_IFID)) begin
         rdata = IFACE_ID;
      end else if (bus_addr == ADDR_W'(OFS_PARTID)) begin
         rdata = PART_ID;
      end else if (in_ctl) begin
         case (bus_addr)
            ADDR_W'(OFS_CTL):    rdata = DATA_W'(status);
            ADDR_W'(OFS_PERIOD): rdata = DATA_W'(period);
            ADDR_W'(OFS_CMP_LO): rdata = cmp_ext[DATA_W-1:0];
            ADDR_W'(OFS_CMP_HI): rdata = cmp_ext[EXT_W-1:DATA_W];
            default:             rdata = '0;
         endcase
      end
   end

endmodule

// File: rtl/wdog_stage.sv
module wdog_stage #(
   parameter int unsigned CNT_W     = 64,
   parameter int unsigned OFF_W     = 32,
   parameter bit          HIT_EXACT = 1'b0
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [CNT_W-1:0]   cnt,
   input  logic [OFF_W-1:0]   period,
   input  logic               en,
   input  logic               kick,
   output logic [CNT_W-1:0]   cmp_q,
   output logic               ws0_q,
   output logic               ws1_q
);

   logic [CNT_W-1:0] deadline;
   logic             hit;

   // one adder serves both the service reload and the first-stage reload
   assign deadline = cnt + CNT_W'(period);

   generate
      if (HIT_EXACT) begin : g_hit_eq
         assign hit = (cnt == cmp_q);
      end else begin : g_hit_ge
         assign hit = (cnt >= cmp_q);
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cmp_q <= '0;
         ws0_q <= 1'b0;
         ws1_q <= 1'b0;
      end else if (kick) begin
         cmp_q <= deadline;
         ws0_q <= 1'b0;
      end else if (en && hit) begin
         if (!ws0_q) begin
            ws0_q <= 1'b1;
            cmp_q <= deadline;
         end else begin
            ws1_q <= 1'b1;
         end
      end
   end

endmodule

// File: rtl/wdog_escalate.sv
module wdog_escalate
   import wdog_pkg::*;
#(
   parameter int unsigned       ADDR_W     = 12,
   parameter int unsigned       DATA_W     = 32,
   parameter int unsigned       OFF_W      = 32,
   parameter int unsigned       CNT_W      = 64,
   parameter bit                HIT_EXACT  = 1'b0,
   parameter logic [OFF_W-1:0]  RST_OFFSET = '0,
   parameter logic [DATA_W-1:0] IFACE_ID   = 32'h5744_0101,
   parameter logic [DATA_W-1:0] PART_ID    = 32'h0000_0E5C
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [CNT_W-1:0]    sys_cnt,
   input  logic                bus_frame,
   input  logic [ADDR_W-1:0]   bus_addr,
   input  logic                bus_wr,
   input  logic [DATA_W-1:0]   bus_wdata,
   output logic [DATA_W-1:0]   bus_rdata,
   output logic                irq_o,
   output logic                rst_req_o
);

   generate
      if (ADDR_W < 12) begin : g_bad_addr
         $error("wdog_escalate: ADDR_W must cover offset 0xFD0");
      end
      if (OFF_W > CNT_W) begin : g_bad_off
         $error("wdog_escalate: OFF_W must not exceed CNT_W");
      end
      if (CNT_W > 2 * DATA_W) begin : g_bad_cnt
         $error("wdog_escalate: compare must fit in two data words");
      end
      if (OFF_W > DATA_W) begin : g_bad_data
         $error("wdog_escalate: offset must fit in one data word");
      end
   endgenerate

   logic             en_q;
   logic [OFF_W-1:0] off_q;
   logic [CNT_W-1:0] cmp_q;
   logic             ws0_q;
   logic             ws1_q;
   logic             kick;
   logic             ctl_wr;
   logic             period_wr;
   wd_status_t       status;

   assign status = '{ws1: ws1_q, ws0: ws0_q, en: en_q};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q  <= 1'b0;
         off_q <= RST_OFFSET;
      end else begin
         if (ctl_wr)    en_q  <= bus_wdata[0];
         if (period_wr) off_q <= bus_wdata[OFF_W-1:0];
      end
   end

   wdog_regdec #(
      .ADDR_W   (ADDR_W),
      .DATA_W   (DATA_W),
      .OFF_W    (OFF_W),
      .CNT_W    (CNT_W),
      .IFACE_ID (IFACE_ID),
      .PART_ID  (PART_ID)
   ) u_dec (
      .bus_frame (bus_frame),
      .bus_addr  (bus_addr),
      .bus_wr    (bus_wr),
      .status    (status),
      .period    (off_q),
      .cmp       (cmp_q),
      .kick      (kick),
      .ctl_wr    (ctl_wr),
      .period_wr (period_wr),
      .rdata     (bus_rdata)
   );

   wdog_stage #(
      .CNT_W     (CNT_W),
      .OFF_W     (OFF_W),
      .HIT_EXACT (HIT_EXACT)
   ) u_stage (
      .clk    (clk),
      .rst_n  (rst_n),
      .cnt    (sys_cnt),
      .period (off_q),
      .en     (en_q),
      .kick   (kick),
      .cmp_q  (cmp_q),
      .ws0_q  (ws0_q),
      .ws1_q  (ws1_q)
   );

   assign irq_o     = ws0_q;
   assign rst_req_o = ws1_q;

endmodule

// File: rtl/wdog_escalate_chk.sv
module wdog_escalate_chk #(
   parameter int unsigned CNT_W = 64,
   parameter int unsigned OFF_W = 32
) (
   input logic             clk,
   input logic             rst_n,
   input logic             irq_o,
   input logic             rst_req_o,
   input logic             en,
   input logic             kick,
   input logic [CNT_W-1:0] cnt,
   input logic [CNT_W-1:0] cmp,
   input logic [OFF_W-1:0] off
);

   // R6: second stage holds until reset
   assert_ws1_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
      rst_req_o |=> rst_req_o);

   // R5: second stage only follows a raised first stage
   assert_ws1_after_ws0_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_req_o) |-> $past(irq_o));

   // R7: no first-stage rise out of a disabled state
   assert_quiet_disabled_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> !$rose(irq_o));

   // R2: a service leaves the first stage clear
   assert_kick_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
      kick |=> !irq_o);

   // R2: a service arms the deadline from the sampled counter
   assert_kick_reload_R2: assert property (@(posedge clk) disable iff (!rst_n)
      kick |=> (cmp == $past(cnt) + CNT_W'($past(off))));

   // R4: first stage rises only when the counter had reached compare
   assert_ws0_on_hit_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq_o) |-> ($past(cnt) >= $past(cmp)) && $past(en));

endmodule

bind wdog_escalate wdog_escalate_chk #(
   .CNT_W (CNT_W),
   .OFF_W (OFF_W)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .irq_o     (irq_o),
   .rst_req_o (rst_req_o),
   .en        (en_q),
   .kick      (kick),
   .cnt       (sys_cnt),
   .cmp       (cmp_q),
   .off       (off_q)
);

// File: tb/sim_wdog_escalate.sv
module sim_wdog_escalate;

   localparam int          PER  = 10;
   localparam logic [63:0] BASE = 64'h0000_0001_FFFF_FFC0;
   localparam logic [31:0] IFID = 32'h5744_0101;
   localparam logic [31:0] PID  = 32'h0000_0E5C;

   typedef struct {
      int          cyc;
      bit          is_rd;
      logic        irq;
      logic        rst;
      logic [31:0] rd;
      string       tag;
   } item_t;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [63:0] sys_cnt;
   logic        bus_frame = 1'b0;
   logic [11:0] bus_addr = '0;
   logic        bus_wr = 1'b0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        irq_o;
   logic        rst_req_o;

   int    cyc = 0;
   int    n_chk = 0;
   int    n_bad = 0;
   bit    done = 1'b0;
   item_t sb[$];

   always #(PER/2) clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;
   assign sys_cnt = BASE + 64'(cyc);

   wdog_escalate u0 (
      .clk       (clk),
      .rst_n     (rst_n),
      .sys_cnt   (sys_cnt),
      .bus_frame (bus_frame),
      .bus_addr  (bus_addr),
      .bus_wr    (bus_wr),
      .bus_wdata (bus_wdata),
      .bus_rdata (bus_rdata),
      .irq_o     (irq_o),
      .rst_req_o (rst_req_o)
   );

   // ---------------- driver side ----------------
   task automatic exp_out(int c, logic i, logic r, string tag);
      item_t it;
      it.cyc = c; it.is_rd = 1'b0; it.irq = i; it.rst = r; it.rd = '0; it.tag = tag;
      sb.push_back(it);
   endtask

   task automatic wr(bit fr, logic [11:0] a, logic [31:0] d, output int k);
      @(negedge clk);
      bus_frame = fr; bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0;
      k = cyc;
   endtask

   task automatic rd(bit fr, logic [11:0] a, logic [31:0] e, string tag);
      item_t it;
      @(negedge clk);
      bus_frame = fr; bus_addr = a;
      it.cyc = cyc; it.is_rd = 1'b1; it.irq = 1'b0; it.rst = 1'b0; it.rd = e; it.tag = tag;
      sb.push_back(it);
      @(negedge clk);
   endtask

   task automatic idle_until(int c);
      while (cyc < c) @(negedge clk);
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
   endtask

   // ---------------- monitor side ----------------
   initial begin
      forever begin
         @(negedge clk);
         #1;
         for (int i = sb.size() - 1; i >= 0; i--) begin
            if (sb[i].cyc == cyc) begin
               n_chk++;
               if (sb[i].is_rd) begin
                  if (bus_rdata !== sb[i].rd) begin
                     n_bad++;
                     $display("FAIL %s: cyc %0d rdata actual=%h expected=%h",
                              sb[i].tag, cyc, bus_rdata, sb[i].rd);
                  end
               end else if (irq_o !== sb[i].irq || rst_req_o !== sb[i].rst) begin
                  n_bad++;
                  $display("FAIL %s: cyc %0d irq/rst actual=%b%b expected=%b%b",
                           sb[i].tag, cyc, irq_o, rst_req_o, sb[i].irq, sb[i].rst);
               end
               sb.delete(i);
            end
         end
      end
   end

   // ---------------- watchdog ----------------
   initial begin
      #(PER * 200000);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog: run hung, actual=running expected=finished");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

   // ---------------- stimulus ----------------
   initial begin
      int k, k2;
      logic [63:0] c;
      do_reset();

      // R1 / R9: reset state and read map
      exp_out(cyc, 1'b0, 1'b0, "R1");
      rd(1'b1, 12'h000, 32'h0, "R1 ctl");
      rd(1'b1, 12'h008, 32'h0, "R1 offset");
      rd(1'b1, 12'hFCC, IFID, "R9 ctl ifid");
      rd(1'b0, 12'hFCC, IFID, "R9 kick ifid");
      rd(1'b1, 12'hFD0, PID, "R9 ctl partid");
      rd(1'b0, 12'hFD0, PID, "R9 kick partid");
      rd(1'b0, 12'h000, 32'h0, "R9 kick reg");
      rd(1'b1, 12'h020, 32'h0, "R9 unmapped");

      // R4 / R5: full escalation with offset 20
      wr(1'b1, 12'h008, 32'd20, k);
      rd(1'b1, 12'h008, 32'd20, "R9 offset");
      wr(1'b1, 12'h000, 32'h1, k);
      c = BASE + 64'(k - 1 + 20);
      exp_out(k + 19, 1'b0, 1'b0, "R4 before");
      exp_out(k + 20, 1'b1, 1'b0, "R4 ws0");
      exp_out(k + 39, 1'b1, 1'b0, "R5 before");
      exp_out(k + 40, 1'b1, 1'b1, "R5 ws1");
      rd(1'b1, 12'h010, c[31:0], "R2 cmp lo");
      rd(1'b1, 12'h014, c[63:32], "R2 cmp hi");
      idle_until(k + 42);
      c = BASE + 64'(k + 39);
      rd(1'b1, 12'h010, c[31:0], "R4 reload lo");
      rd(1'b1, 12'h014, c[63:32], "R4 reload hi");
      rd(1'b1, 12'h000, 32'h7, "R9 ctl status");

      // R6: sticky second stage
      wr(1'b0, 12'h000, 32'hDEAD_BEEF, k2);
      exp_out(k2, 1'b0, 1'b1, "R6 after kick");
      wr(1'b1, 12'h000, 32'h0, k2);
      exp_out(k2 + 5, 1'b0, 1'b1, "R6 after disable");
      idle_until(k2 + 7);
      do_reset();
      exp_out(cyc, 1'b0, 1'b0, "R6 cleared by reset");
      rd(1'b1, 12'h000, 32'h0, "R1 ctl after reset");

      // R2: kick before and after first stage
      wr(1'b1, 12'h008, 32'd20, k);
      wr(1'b1, 12'h000, 32'h1, k);
      idle_until(k + 10);
      wr(1'b0, 12'h000, 32'h0, k2);
      exp_out(k + 20, 1'b0, 1'b0, "R2 postponed");
      exp_out(k2 + 19, 1'b0, 1'b0, "R2 before");
      exp_out(k2 + 20, 1'b1, 1'b0, "R2 ws0");
      idle_until(k2 + 22);
      wr(1'b0, 12'h000, 32'h5, k);
      exp_out(k, 1'b0, 1'b0, "R2 clears ws0");
      exp_out(k + 19, 1'b0, 1'b0, "R2 rearmed");
      exp_out(k + 20, 1'b1, 1'b0, "R2 ws0 again");
      idle_until(k + 22);

      // R7: disable clears and stays quiet
      wr(1'b1, 12'h000, 32'h0, k);
      exp_out(k, 1'b0, 1'b0, "R7 disable clears");
      exp_out(k + 60, 1'b0, 1'b0, "R7 quiet");
      idle_until(k + 61);
      rd(1'b1, 12'h000, 32'h0, "R7 ctl");

      // R3: control write refreshes, status bits ignored
      wr(1'b1, 12'h000, 32'h1, k);
      idle_until(k + 22);
      wr(1'b1, 12'h000, 32'h7, k2);
      exp_out(k2, 1'b0, 1'b0, "R3 refresh");
      rd(1'b1, 12'h000, 32'h1, "R3 ws bits ignored");
      exp_out(k2 + 19, 1'b0, 1'b0, "R3 before");
      exp_out(k2 + 20, 1'b1, 1'b0, "R3 ws0");
      idle_until(k2 + 21);
      wr(1'b1, 12'h000, 32'h0, k);

      // R10: kick on the hit edge wins
      wr(1'b1, 12'h000, 32'h1, k);
      idle_until(k + 18);
      wr(1'b0, 12'h000, 32'h0, k2);
      exp_out(k2, 1'b0, 1'b0, "R10 kick wins");
      exp_out(k2 + 19, 1'b0, 1'b0, "R10 before");
      exp_out(k2 + 20, 1'b1, 1'b0, "R10 ws0");
      idle_until(k2 + 21);
      wr(1'b1, 12'h000, 32'h0, k);

      // R8: offset zero
      wr(1'b1, 12'h008, 32'd0, k);
      wr(1'b1, 12'h000, 32'h1, k);
      exp_out(k, 1'b0, 1'b0, "R8 at enable");
      exp_out(k + 1, 1'b1, 1'b0, "R8 ws0");
      exp_out(k + 2, 1'b1, 1'b1, "R8 ws1");
      idle_until(k + 4);

      idle_until(cyc + 3);
      if (sb.size() != 0) begin
         n_bad++;
         $display("FAIL scoreboard: actual=%0d pending expected=0", sb.size());
      end
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

endmodule